// File: doc/BRIEF.md
# Byte-Register Access Slave for a Two-Wire Serial Bus

This block is an I2C target that gives an external bus controller read and write access to a bank of up to 256 byte-wide registers. The registers themselves live in the logic around the block. The block works entirely in one system clock domain. It samples the bus clock and data lines through synchronizers and finds bus edges, START and STOP from the sampled values. It pulls the data line low through an output-enable and never drives it high.

In a write transaction, the byte after the target address loads an internal register pointer. Each later byte is presented on a write-data port together with a one-cycle valid strobe, and the pointer then steps by one. In a read transaction, the surrounding logic selects one of its registers with the pointer output and feeds that value back on the read-data input. The block shifts that byte out and steps the pointer after every byte. A repeated START keeps the pointer. This allows the usual "write the pointer, repeated START, read" access pattern.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is asserted, sda_oe is 0, wr_valid is 0 and reg_addr is 0x00.
- R2: The block pulls SDA low during the acknowledge bit only when the 7 address bits (sent MSB first, followed by a direction bit, 0 = write, 1 = read) match the SLV_ADDR parameter. On any other address it gives no acknowledge, produces no strobe and leaves reg_addr unchanged for the rest of that transaction.
- R3: In a write transaction, the first byte after the address is acknowledged and loads reg_addr. It produces no wr_valid strobe.
- R4: Each later written byte is acknowledged and produces exactly one wr_valid cycle. During that cycle wr_data holds the byte and reg_addr holds the target register. wr_data stays unchanged in the cycle after the strobe.
- R5: reg_addr increases by one in the cycle after each wr_valid strobe, wrapping from 0xFF to 0x00.
- R6: In a read transaction, each byte is sent MSB first. Its value is rd_data as it stood when the byte began, selected by reg_addr. reg_addr increases by one after every byte read.
- R7: A read continues with the next byte while the controller acknowledges. After a not-acknowledge the block releases SDA and stops sending.
- R8: A repeated START restarts address reception but keeps the pointer, so a read after "pointer write, repeated START" begins at the written pointer.
- R9: After a STOP, or after any START, SDA is released in the next cycle.
- R10: sda_oe only turns on while SCL is low; it never changes while the raw SCL input is high during well-formed transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| reg_addr | output | 8 | Current register pointer |
| wr_data | output | 8 | Last data byte written by the controller |
| wr_valid | output | 1 | One-cycle strobe marking a new wr_data byte |
| rd_data | input | 8 | Register value selected by reg_addr, returned on reads |

## Verification
The bench sends a transaction to a foreign address. A block that decoded the address loosely would acknowledge it, or would let the following byte move the pointer. Bursts are placed across the 0xFF to 0x00 boundary. A block with a pointer of the wrong width or with a stuck increment would strobe data at the wrong addresses, and the scoreboard would reject those. Reads follow a pointer write and a repeated START, then end with a not-acknowledge. A block that cleared the pointer on START would read from the wrong register, and one that ignored the not-acknowledge would still hold SDA low afterwards. A side monitor flags any change of the output-enable while SCL is high, which is the case where the bus would see a false START or STOP.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } i2c_state_e;
endpackage

// File: rtl/i2c_sync.sv
// Multi-stage synchronizer for asynchronous bus lines; idles high.
module i2c_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_cond_det.sv
// Edge and bus-condition detection on synchronized lines.
module i2c_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_fsm.sv
// Protocol engine: address match, pointer load, write burst, read burst.
module i2c_reg_fsm
  import i2c_reg_pkg::*;
#(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-2:0] SLV_ADDR = 7'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_valid
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  i2c_state_e        st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sr, sr_n, tx, tx_n, ptr, ptr_n, wdat, wdat_n;
  logic              rw, rw_n, ptr_ph, ptr_ph_n, mack, mack_n;
  logic              wvld, wvld_n, oe, oe_n;
  logic              done;

  assign done = (cnt == CNT_FULL);

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    sr_n     = sr;
    tx_n     = tx;
    rw_n     = rw;
    ptr_ph_n = ptr_ph;
    mack_n   = mack;
    ptr_n    = ptr;
    wdat_n   = wdat;
    wvld_n   = 1'b0;
    oe_n     = oe;
    if (wvld) ptr_n = ptr + 1'b1;
    if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise && !done) begin
            sr_n  = {sr[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && done) begin
            if (sr[BYTE_W-1:1] == SLV_ADDR) begin
              oe_n = 1'b1;
              rw_n = sr[0];
              st_n = ST_ADDR_ACK;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              tx_n = rd_data;
              oe_n = ~rd_data[BYTE_W-1];
              st_n = ST_RD;
            end else begin
              oe_n     = 1'b0;
              ptr_ph_n = 1'b1;
              st_n     = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise && !done) begin
            sr_n  = {sr[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && done) begin
            oe_n = 1'b1;
            st_n = ST_WR_ACK;
            if (ptr_ph) begin
              ptr_n    = sr;
              ptr_ph_n = 1'b0;
            end else begin
              wdat_n = sr;
              wvld_n = 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            st_n  = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise && !done) begin
            cnt_n = cnt + 1'b1;
          end else if (scl_fall) begin
            if (done) begin
              oe_n  = 1'b0;
              ptr_n = ptr + 1'b1;
              st_n  = ST_RD_ACK;
            end else begin
              tx_n = {tx[BYTE_W-2:0], tx[BYTE_W-1]};
              oe_n = ~tx[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx_n  = rd_data;
              oe_n  = ~rd_data[BYTE_W-1];
              cnt_n = '0;
              st_n  = ST_RD;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sr     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      ptr_ph <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      wdat   <= '0;
      wvld   <= 1'b0;
      oe     <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      sr     <= sr_n;
      tx     <= tx_n;
      rw     <= rw_n;
      ptr_ph <= ptr_ph_n;
      mack   <= mack_n;
      ptr    <= ptr_n;
      wdat   <= wdat_n;
      wvld   <= wvld_n;
      oe     <= oe_n;
    end
  end

  assign sda_oe   = oe;
  assign reg_addr = ptr;
  assign wr_data  = wdat;
  assign wr_valid = wvld;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int         BYTE_W   = 8,
  parameter int         SYNC_STG = 2,
  parameter logic [6:0] SLV_ADDR = 7'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_valid,
  input  logic [BYTE_W-1:0] rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    ({scl_s, sda_s})
  );

  i2c_cond_det u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_reg_fsm #(.BYTE_W(BYTE_W), .SLV_ADDR(SLV_ADDR)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .wr_valid (wr_valid)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              wr_valid,
  input logic [BYTE_W-1:0] wr_data,
  input logic [BYTE_W-1:0] reg_addr
);
  // R4: strobe lasts one cycle
  a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R4: written byte held after strobe
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> $stable(wr_data));

  // R5: pointer steps by one after strobe
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (reg_addr == $past(reg_addr) + 1'b1));

  // R9: STOP releases the line
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R9: START releases the line
  a_r9_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R10: drive only begins while sampled SCL is low
  a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .wr_valid (wr_valid),
  .wr_data  (wr_data),
  .reg_addr (reg_addr)
);

// File: tb/i2c_reg_slave_bench.sv
`timescale 1ns/1ps
module i2c_reg_slave_bench;
  localparam logic [6:0] SLV = 7'h42;
  localparam int Q = 8;
  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, wr_valid;
  logic [7:0] reg_addr, wr_data, rd_data;
  logic       sda_bus;

  logic [7:0]  regfile [256];
  logic [7:0]  exp_mem [256];
  logic [15:0] exp_q [$];
  logic [7:0]  ptr_exp;
  int n_chk = 0, n_fail = 0, oe_viol = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = regfile[reg_addr];

  i2c_reg_slave #(.SLV_ADDR(SLV)) u_i2c_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .wr_data(wr_data),
    .wr_valid(wr_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q); scl = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q); scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q); scl = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; wclk(Q); scl = 1'b1; wclk(H/2);
    s = sda_bus; wclk(H/2); scl = 1'b0; wclk(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = (s == 1'b0);
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(give_ack ? 1'b0 : 1'b1, s);
  endtask

  // driver: push expected register write, then send the byte
  task automatic wr_data_byte(input logic [7:0] b, input string tag);
    bit ack;
    exp_q.push_back({ptr_exp, b});
    exp_mem[ptr_exp] = b;
    ptr_exp = ptr_exp + 8'd1;
    wr_byte(b, ack);
    chk(ack, tag, ack, 1);
  endtask

  // monitor: scoreboard compare and register-file model
  initial begin
    logic [15:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && wr_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected strobe", {reg_addr, wr_data}, 0);
        end else begin
          e = exp_q.pop_front();
          chk({reg_addr, wr_data} == e, "R4 strobe addr/data", {reg_addr, wr_data}, e);
        end
        regfile[reg_addr] = wr_data;
      end
    end
  end

  // R10 monitor: output-enable must not move while SCL is high
  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && scl && (sda_oe != prev)) oe_viol++;
      prev = sda_oe;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) begin
      regfile[i] = 8'(i * 7 + 3) ^ 8'h5A;
      exp_mem[i] = regfile[i];
    end
    ptr_exp = 8'h00;
    wclk(5);
    chk(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
    chk(wr_valid == 1'b0, "R1 wr_valid in reset", wr_valid, 0);
    chk(reg_addr == 8'h00, "R1 reg_addr in reset", reg_addr, 0);
    rst_n = 1'b1;
    wclk(10);

    // R2: foreign address
    bus_start();
    wr_byte({7'h2C, 1'b0}, ack);
    chk(!ack, "R2 foreign address acked", ack, 0);
    wr_byte(8'hAA, ack);
    chk(!ack, "R2 byte after foreign address acked", ack, 0);
    bus_stop();
    chk(reg_addr == 8'h00, "R2 pointer moved", reg_addr, 0);

    // R3/R4/R5: pointer then burst
    bus_start();
    wr_byte({SLV, 1'b0}, ack);
    chk(ack, "R2 own address ack", ack, 1);
    wr_byte(8'h20, ack);
    ptr_exp = 8'h20;
    chk(ack, "R3 pointer byte ack", ack, 1);
    chk(reg_addr == 8'h20, "R3 pointer load", reg_addr, 8'h20);
    chk(exp_q.size() == 0 && n_fail == 0, "R3 strobe on pointer byte", n_fail, 0);
    wr_data_byte(8'h11, "R4 data ack");
    wr_data_byte(8'h22, "R4 data ack");
    wr_data_byte(8'h33, "R4 data ack");
    bus_stop();
    chk(reg_addr == 8'h23, "R5 pointer after burst", reg_addr, 8'h23);
    chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);

    // R5: wrap
    bus_start();
    wr_byte({SLV, 1'b0}, ack);
    wr_byte(8'hFE, ack);
    ptr_exp = 8'hFE;
    wr_data_byte(8'hA1, "R5 wrap ack");
    wr_data_byte(8'hA2, "R5 wrap ack");
    wr_data_byte(8'hA3, "R5 wrap ack");
    bus_stop();
    chk(reg_addr == 8'h01, "R5 pointer wrap", reg_addr, 8'h01);

    // R8/R6/R7: pointer write, repeated START, read burst
    bus_start();
    wr_byte({SLV, 1'b0}, ack);
    wr_byte(8'h21, ack);
    bus_start();
    wr_byte({SLV, 1'b1}, ack);
    chk(ack, "R2 read address ack", ack, 1);
    rd_byte(1'b1, b);
    chk(b == exp_mem[8'h21], "R8 first read after Sr", b, exp_mem[8'h21]);
    rd_byte(1'b1, b);
    chk(b == exp_mem[8'h22], "R6 burst read 2", b, exp_mem[8'h22]);
    rd_byte(1'b0, b);
    chk(b == exp_mem[8'h23], "R6 burst read 3", b, exp_mem[8'h23]);
    wclk(Q);
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    chk(reg_addr == 8'h24, "R6 pointer after reads", reg_addr, 8'h24);
    bus_stop();

    // R6: read from current pointer, no pointer write
    bus_start();
    wr_byte({SLV, 1'b1}, ack);
    rd_byte(1'b0, b);
    chk(b == exp_mem[8'h24], "R6 read at current pointer", b, exp_mem[8'h24]);
    bus_stop();
    chk(reg_addr == 8'h25, "R6 pointer step", reg_addr, 8'h25);

    // R6/R8: read back across wrap
    bus_start();
    wr_byte({SLV, 1'b0}, ack);
    wr_byte(8'hFF, ack);
    bus_start();
    wr_byte({SLV, 1'b1}, ack);
    rd_byte(1'b1, b);
    chk(b == exp_mem[8'hFF], "R8 read back 0xFF", b, exp_mem[8'hFF]);
    rd_byte(1'b0, b);
    chk(b == exp_mem[8'h00], "R6 read back wrap 0x00", b, exp_mem[8'h00]);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 released after final stop", sda_oe, 0);

    wclk(10);
    chk(exp_q.size() == 0, "R4 missing strobes", exp_q.size(), 0);
    chk(oe_viol == 0, "R10 oe change while SCL high", oe_viol, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule